// File: doc/BRIEF.md
# Dual-Output Programmable Interrupt Controller

This block gathers 64 interrupt lines into two processor request outputs, a normal request and a fast request. The lines form two banks of 32. A low bank covers lines 0 to 31 and an extended bank covers lines 32 to 63. Each bank has two independent register groups, one feeding the normal request and one feeding the fast request. Each group holds a raw source word, an enable word, a trigger-mode word, a polarity word, a write-one-to-clear strobe and a masked status word.

Every line can be made level sensitive or edge sensitive, and active high or active low, separately in each group. Level-sensitive source bits track the line. Edge-sensitive source bits latch a transition and hold it until software clears it.

Software reaches the registers through a plain 32-bit register bus. A write completes in the single cycle in which the write strobe is high, and the read data is combinational from the address. All interrupt lines share the controller's clock domain.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Reset clears every source, enable, mode and polarity bit, and the stored line history, in all four groups. Both request outputs are low during reset and after it.
- R2: A level-mode bit (mode bit 0) holds 1 while its line is at the active level and 0 otherwise. Polarity bit 0 means active high and polarity bit 1 means active low. The source bit registers the line state one clock after it is sampled.
- R3: An edge-mode bit (mode bit 1) is set when the line goes from inactive to active, comparing the current sample with the previous one. Polarity 0 selects a rising edge and polarity 1 a falling edge. The bit stays set when the line goes back.
- R4: Writing the clear word of a group drops the source bits that are written as 1 and are in edge mode. Level-mode bits are not touched. If an edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R5: Masked status reads as source AND enable. The normal request output is the OR of masked status over both normal groups, registered, so it follows a source or enable change by one clock.
- R6: The fast-request groups use their own mode, polarity and enable words, apart from the normal groups. A clear written to a normal group leaves the fast groups alone. The fast request output is the OR of the fast masked status, registered.
- R7: The word offsets within a group are: source 0x00, enable 0x04, clear 0x08, mode 0x0C, polarity 0x10, status 0x14. The group bases are 0x00 (low normal), 0x20 (low fast), 0x60 (extended normal) and 0x80 (extended fast).
- R8: A read of a clear word, of an unaligned address or of any address outside the groups returns 0. A write to a source word, a status word or an unmapped address changes nothing.
- R9: Line 32+k drives bit k of the extended groups and leaves the low groups unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 64 | Interrupt lines, bit n is line n |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| irqReq | output | 1 | Normal interrupt request |
| fiqReq | output | 1 | Fast interrupt request |

## Verification
The bench drives a clear into a bit on the same cycle as a new edge. A design that let the clear win would lose that interrupt. It also clears a mix of level and edge bits with one write; a design that ignored the mode would drop a level bit whose line is still active. It configures the fast group differently from the normal group on the same line and clears only the normal group. Shared state between the groups would show up as a missing or phantom fast request. Reads of holes, of unaligned addresses and of clear words must return zero. Writes to read-only words must leave the enable and mode words untouched.

// File: rtl/dual_irq_pkg.sv
`timescale 1ns/1ps
package dual_irq_pkg;
  localparam int BANKS        = 2;
  localparam int LINES        = 32;
  localparam int CLASSES      = 2;
  localparam int UNITS        = BANKS * CLASSES;
  localparam int UNIT_IDX_W   = $clog2(UNITS);
  localparam int ADDR_W       = 8;
  localparam int DATA_W       = LINES;
  localparam int TOTAL_LINES  = BANKS * LINES;
  localparam int CLASS_STRIDE = 'h20;
  localparam int BANK_STRIDE  = 'h60;
  localparam int GROUP_WORDS  = 6;
  localparam int CLASS_IRQ    = 0;
  localparam int CLASS_FIQ    = 1;

  typedef enum logic [2:0] {
    FLD_SRC  = 3'd0,
    FLD_ENA  = 3'd1,
    FLD_CLR  = 3'd2,
    FLD_MODE = 3'd3,
    FLD_POL  = 3'd4,
    FLD_STAT = 3'd5,
    FLD_NONE = 3'd7
  } regField_e;

  typedef struct packed {
    logic [UNITS-1:0]      wrEna;
    logic [UNITS-1:0]      wrClr;
    logic [UNITS-1:0]      wrMode;
    logic [UNITS-1:0]      wrPol;
    logic [UNIT_IDX_W-1:0] rdUnit;
    regField_e             rdField;
  } regStrobe_t;

  function automatic int unitBase(int u);
    return (u / CLASSES) * BANK_STRIDE + (u % CLASSES) * CLASS_STRIDE;
  endfunction
endpackage

// File: rtl/dual_irq_decode.sv
`timescale 1ns/1ps
module dual_irq_decode
  import dual_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);
  logic [UNITS-1:0] unitHit;
  logic [2:0]       unitWord [UNITS];

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(unitBase(u));
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(unitBase(u) + GROUP_WORDS * 4);
    logic [ADDR_W-1:0] relAddr;
    assign relAddr     = busAddr - BASE;
    assign unitHit[u]  = (busAddr[1:0] == 2'b00) && (busAddr >= BASE) && (busAddr < LIMIT);
    assign unitWord[u] = relAddr[4:2];
  end

  always_comb begin
    strobe         = '0;
    strobe.rdField = FLD_NONE;
    for (int u = 0; u < UNITS; u++) begin
      if (unitHit[u]) begin
        strobe.rdUnit  = UNIT_IDX_W'(u);
        strobe.rdField = regField_e'(unitWord[u]);
        if (busWrEn) begin
          case (unitWord[u])
            3'd1:    strobe.wrEna[u]  = 1'b1;
            3'd2:    strobe.wrClr[u]  = 1'b1;
            3'd3:    strobe.wrMode[u] = 1'b1;
            3'd4:    strobe.wrPol[u]  = 1'b1;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dual_irq_datapath.sv
`timescale 1ns/1ps
module dual_irq_datapath
  import dual_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TOTAL_LINES-1:0] irqLines,
  input  logic [DATA_W-1:0]      busWrData,
  input  regStrobe_t             strobe,
  output logic [DATA_W-1:0]      busRdData,
  output logic                   irqReq,
  output logic                   fiqReq
);
  logic [TOTAL_LINES-1:0]        prevPin;
  logic [UNITS-1:0][LINES-1:0]   srcArr, enaArr, modeArr, polArr;
  logic [UNITS-1:0]              pend;
  logic                          irqAny, fiqAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '0;
    else       prevPin <= irqLines;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_grp
    localparam int BANK = u / CLASSES;
    logic [LINES-1:0] srcQ, enaQ, modeQ, polQ;
    logic [LINES-1:0] actNow, actOld, edgeHit, clrMask, srcNext;

    assign actNow  = irqLines[BANK*LINES +: LINES] ^ polQ;
    assign actOld  = prevPin[BANK*LINES +: LINES] ^ polQ;
    assign edgeHit = actNow & ~actOld;
    assign clrMask = strobe.wrClr[u] ? busWrData : '0;
    assign srcNext = (modeQ & ((srcQ & ~clrMask) | edgeHit)) | (~modeQ & actNow);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ  <= '0;
        enaQ  <= '0;
        modeQ <= '0;
        polQ  <= '0;
      end else begin
        srcQ <= srcNext;
        if (strobe.wrEna[u])  enaQ  <= busWrData;
        if (strobe.wrMode[u]) modeQ <= busWrData;
        if (strobe.wrPol[u])  polQ  <= busWrData;
      end
    end

    assign srcArr[u]  = srcQ;
    assign enaArr[u]  = enaQ;
    assign modeArr[u] = modeQ;
    assign polArr[u]  = polQ;
    assign pend[u]    = |(srcQ & enaQ);
  end

  always_comb begin
    irqAny = 1'b0;
    fiqAny = 1'b0;
    for (int u = 0; u < UNITS; u++) begin
      if ((u % CLASSES) == CLASS_IRQ) irqAny = irqAny | pend[u];
      if ((u % CLASSES) == CLASS_FIQ) fiqAny = fiqAny | pend[u];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      fiqReq <= 1'b0;
    end else begin
      irqReq <= irqAny;
      fiqReq <= fiqAny;
    end
  end

  always_comb begin
    case (strobe.rdField)
      FLD_SRC:  busRdData = srcArr[strobe.rdUnit];
      FLD_ENA:  busRdData = enaArr[strobe.rdUnit];
      FLD_MODE: busRdData = modeArr[strobe.rdUnit];
      FLD_POL:  busRdData = polArr[strobe.rdUnit];
      FLD_STAT: busRdData = srcArr[strobe.rdUnit] & enaArr[strobe.rdUnit];
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
`timescale 1ns/1ps
module dual_irq_ctrl
  import dual_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TOTAL_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic [DATA_W-1:0]      busWrData,
  output logic [DATA_W-1:0]      busRdData,
  output logic                   irqReq,
  output logic                   fiqReq
);
  regStrobe_t strobe;

  dual_irq_decode decode_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  dual_irq_datapath datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .irqLines  (irqLines),
    .busWrData (busWrData),
    .strobe    (strobe),
    .busRdData (busRdData),
    .irqReq    (irqReq),
    .fiqReq    (fiqReq)
  );
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
`timescale 1ns/1ps
module dual_irq_ctrl_chk
  import dual_irq_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [TOTAL_LINES-1:0] irqLines,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWrEn,
  input logic [DATA_W-1:0]      busRdData,
  input logic                   irqReq,
  input logic                   fiqReq
);
  logic [TOTAL_LINES-1:0] lastLines;
  logic [2:0]             quietCnt;
  logic                   irqEnaSeen, fiqEnaSeen;
  logic                   isClr, isMapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLines  <= '0;
      quietCnt   <= '0;
      irqEnaSeen <= 1'b0;
      fiqEnaSeen <= 1'b0;
    end else begin
      lastLines <= irqLines;
      if (!busWrEn && irqLines == lastLines) begin
        if (quietCnt != 3'd7) quietCnt <= quietCnt + 3'd1;
      end else begin
        quietCnt <= '0;
      end
      if (busWrEn && (busAddr == 8'h04 || busAddr == 8'h64)) irqEnaSeen <= 1'b1;
      if (busWrEn && (busAddr == 8'h24 || busAddr == 8'h84)) fiqEnaSeen <= 1'b1;
    end
  end

  assign isClr = (busAddr == 8'h08) || (busAddr == 8'h28) ||
                 (busAddr == 8'h68) || (busAddr == 8'h88);

  always_comb begin
    isMapped = 1'b0;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr <= 8'h14) isMapped = 1'b1;
      if (busAddr >= 8'h20 && busAddr <= 8'h34) isMapped = 1'b1;
      if (busAddr >= 8'h60 && busAddr <= 8'h74) isMapped = 1'b1;
      if (busAddr >= 8'h80 && busAddr <= 8'h94) isMapped = 1'b1;
    end
  end

  AST_QUIET_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rstN) (quietCnt >= 3'd4) |-> ($stable(irqReq) && $stable(fiqReq))); // R5
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN) irqReq |-> irqEnaSeen); // R5
  AST_FIQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN) fiqReq |-> fiqEnaSeen); // R6
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN) isClr |-> (busRdData == '0)); // R8
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN) !isMapped |-> (busRdData == '0)); // R8
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk chk_i (.*);

// File: tb/dual_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqLines = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqReq, fiqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;
  bit running  = 1'b0;

  always #2.5 clk = ~clk;

  dual_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqReq(irqReq), .fiqReq(fiqReq)
  );

  // behavioural reference: group g = bank*2 + class, base = bank*0x60 + class*0x20
  logic [31:0] mSrc [4];
  logic [31:0] mEna [4];
  logic [31:0] mMode[4];
  logic [31:0] mPol [4];
  logic [63:0] mPrev;
  logic        mIrq, mFiq;

  always @(posedge clk or negedge rstN) begin : refModel
    logic [31:0] nSrc [4];
    if (!rstN) begin
      for (int g = 0; g < 4; g++) begin
        mSrc[g] = 0; mEna[g] = 0; mMode[g] = 0; mPol[g] = 0;
      end
      mPrev = 0; mIrq = 0; mFiq = 0;
    end else begin
      mIrq = ((mSrc[0] & mEna[0]) != 0) || ((mSrc[2] & mEna[2]) != 0);
      mFiq = ((mSrc[1] & mEna[1]) != 0) || ((mSrc[3] & mEna[3]) != 0);
      for (int g = 0; g < 4; g++) begin
        int base;
        base = (g / 2) * 'h60 + (g % 2) * 'h20;
        for (int b = 0; b < 32; b++) begin
          bit cur, old, act, oldAct, clrHit;
          cur    = irqLines[(g / 2) * 32 + b];
          old    = mPrev[(g / 2) * 32 + b];
          act    = cur ^ mPol[g][b];
          oldAct = old ^ mPol[g][b];
          clrHit = busWrEn && (int'(busAddr) == base + 8) && busWrData[b];
          if (mMode[g][b]) begin
            if (act && !oldAct)  nSrc[g][b] = 1'b1;
            else if (clrHit)     nSrc[g][b] = 1'b0;
            else                 nSrc[g][b] = mSrc[g][b];
          end else begin
            nSrc[g][b] = act;
          end
        end
        if (busWrEn && int'(busAddr) == base + 'h04) mEna[g]  = busWrData;
        if (busWrEn && int'(busAddr) == base + 'h0C) mMode[g] = busWrData;
        if (busWrEn && int'(busAddr) == base + 'h10) mPol[g]  = busWrData;
      end
      for (int g = 0; g < 4; g++) mSrc[g] = nSrc[g];
      mPrev = irqLines;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && running) begin
      chk(irqReq == mIrq, "R5 irqReq vs model", {31'd0, irqReq}, {31'd0, mIrq});
      chk(fiqReq == mFiq, "R6 fiqReq vs model", {31'd0, fiqReq}, {31'd0, mFiq});
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setLine(input int idx, input bit v);
    @(negedge clk);
    irqLines[idx] = v;
  endtask

  task automatic rdExpect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #0.5;
    chk(busRdData == exp, tag, busRdData, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic outExpect(input bit expIrq, input bit expFiq, input string tag);
    @(negedge clk);
    chk(irqReq == expIrq && fiqReq == expFiq, tag, {30'd0, irqReq, fiqReq}, {30'd0, expIrq, expFiq});
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    // R1: reset state
    rdExpect(8'h00, 32'h0, "R1 low irq source");
    rdExpect(8'h04, 32'h0, "R1 low irq enable");
    rdExpect(8'h0C, 32'h0, "R1 low irq mode");
    rdExpect(8'h10, 32'h0, "R1 low irq polarity");
    rdExpect(8'h60, 32'h0, "R1 ext irq source");
    rdExpect(8'h84, 32'h0, "R1 ext fiq enable");
    outExpect(1'b0, 1'b0, "R1 outputs after reset");

    // R2: level mode, both polarities
    wrReg(8'h04, 32'h28);
    setLine(3, 1'b1);
    rdExpect(8'h00, 32'h08, "R2 level active high sets");
    rdExpect(8'h14, 32'h08, "R5 status is src and ena");
    wrReg(8'h10, 32'h20);
    rdExpect(8'h00, 32'h28, "R2 active low with line low");
    setLine(3, 1'b0);
    rdExpect(8'h00, 32'h20, "R2 level drops with line");
    settle();
    outExpect(1'b1, 1'b0, "R5 irq from level bit");
    setLine(5, 1'b1);
    rdExpect(8'h00, 32'h00, "R2 active low released");
    settle();
    outExpect(1'b0, 1'b0, "R5 irq drops");
    setLine(5, 1'b0);
    wrReg(8'h10, 32'h0);
    rdExpect(8'h00, 32'h00, "R2 polarity restored");

    // R3: edge mode
    wrReg(8'h0C, 32'h180);
    wrReg(8'h10, 32'h100);
    wrReg(8'h04, 32'h180);
    rdExpect(8'h0C, 32'h180, "R7 mode word at 0x0C");
    rdExpect(8'h10, 32'h100, "R7 polarity word at 0x10");
    rdExpect(8'h00, 32'h00, "R3 no edge on configuration");
    setLine(7, 1'b1);
    rdExpect(8'h00, 32'h80, "R3 rising edge sets");
    setLine(7, 1'b0);
    rdExpect(8'h00, 32'h80, "R3 edge bit sticky");
    settle();
    outExpect(1'b1, 1'b0, "R5 irq from edge bit");
    setLine(7, 1'b1);
    wrReg(8'h08, 32'h80);
    rdExpect(8'h00, 32'h00, "R4 clear drops edge bit");
    rdExpect(8'h08, 32'h00, "R8 clear word reads zero");
    setLine(8, 1'b1);
    rdExpect(8'h00, 32'h00, "R3 rising ignored in falling mode");
    setLine(8, 1'b0);
    rdExpect(8'h00, 32'h100, "R3 falling edge sets");

    // R4: clear leaves level bits, set beats clear
    setLine(3, 1'b1);
    rdExpect(8'h00, 32'h108, "R4 level and edge bits set");
    wrReg(8'h08, 32'h108);
    rdExpect(8'h00, 32'h08, "R4 level bit survives clear");
    setLine(3, 1'b0);
    setLine(7, 1'b0);
    rdExpect(8'h00, 32'h00, "R4 both bits gone");
    @(negedge clk);
    irqLines[7] = 1'b1;
    busAddr = 8'h08; busWrData = 32'h80; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    rdExpect(8'h00, 32'h80, "R4 edge wins over clear");
    wrReg(8'h08, 32'h80);
    setLine(7, 1'b0);
    rdExpect(8'h00, 32'h00, "R4 cleared after race");

    // R6: fast group configured apart
    wrReg(8'h2C, 32'h08);
    wrReg(8'h24, 32'h08);
    setLine(3, 1'b1);
    rdExpect(8'h00, 32'h08, "R6 normal group level");
    rdExpect(8'h20, 32'h08, "R6 fast group edge");
    setLine(3, 1'b0);
    rdExpect(8'h00, 32'h00, "R6 normal level dropped");
    rdExpect(8'h20, 32'h08, "R6 fast edge sticky");
    rdExpect(8'h34, 32'h08, "R6 fast status");
    settle();
    outExpect(1'b0, 1'b1, "R6 fast request only");
    wrReg(8'h08, 32'h08);
    rdExpect(8'h20, 32'h08, "R6 normal clear leaves fast");
    wrReg(8'h28, 32'h08);
    rdExpect(8'h20, 32'h00, "R6 fast clear works");
    settle();
    outExpect(1'b0, 1'b0, "R6 fast request drops");

    // R9: extended bank
    wrReg(8'h64, 32'h100);
    setLine(40, 1'b1);
    rdExpect(8'h60, 32'h100, "R9 ext normal source");
    rdExpect(8'h74, 32'h100, "R9 ext normal status");
    rdExpect(8'h80, 32'h100, "R9 ext fast source");
    rdExpect(8'h94, 32'h000, "R9 ext fast status masked");
    rdExpect(8'h00, 32'h000, "R9 low bank untouched");
    settle();
    outExpect(1'b1, 1'b0, "R9 ext drives irq");
    setLine(40, 1'b0);
    rdExpect(8'h60, 32'h000, "R9 ext source drops");

    // R8: holes and read-only words
    rdExpect(8'h18, 32'h0, "R8 hole after group");
    rdExpect(8'h40, 32'h0, "R8 hole between banks");
    rdExpect(8'hA0, 32'h0, "R8 beyond map");
    rdExpect(8'h06, 32'h0, "R8 unaligned");
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdExpect(8'h00, 32'h0, "R8 source write ignored");
    wrReg(8'h14, 32'hFFFF_FFFF);
    rdExpect(8'h04, 32'h180, "R8 status write ignored");
    wrReg(8'h18, 32'hFFFF_FFFF);
    rdExpect(8'h0C, 32'h180, "R8 hole write ignored");
    rdExpect(8'h2C, 32'h08, "R7 fast mode word at 0x2C");

    // R1: reset mid-run
    @(negedge clk);
    running = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk(irqReq == 1'b0 && fiqReq == 1'b0, "R1 outputs low in reset", {30'd0, irqReq, fiqReq}, 32'd0);
    rstN = 1'b1;
    running = 1'b1;
    rdExpect(8'h0C, 32'h0, "R1 mode cleared");
    rdExpect(8'h04, 32'h0, "R1 enable cleared");
    rdExpect(8'h2C, 32'h0, "R1 fast mode cleared");
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule